// File: doc/BRIEF.md
# Serial Byte Transmitter with Selectable Queue

This block turns bytes written by a host into asynchronous serial frames on a single output line. Each accepted byte waits in a staging store and is then handed to a frame sequencer, which drives the line. The store holds up to 64 bytes when queue mode is on, or one byte when it is off. A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The line stays high between frames.

Bit timing comes from an external oversampling strobe `tick`. One bit lasts 16 strobes, or 8 strobes when the half-rate option is selected. Two flags show how far the data has drained. `hold_empty` is set when no byte waits in the staging store. `shift_empty` is set only when the sequencer has also finished its last stop bit. A transmit interrupt follows `hold_empty` and is gated by an enable input. A write that finds the store full is discarded and sets a sticky overflow flag.

The sequencer has five states. IDLE holds the line high. IDLE goes to START when a byte is waiting, and that byte is taken from the store in the same cycle. START goes to DATA after one bit time. DATA goes to PARITY after the last data bit if parity is on, otherwise to STOP. PARITY goes to STOP after one bit time. STOP goes back to IDLE after its last stop bit.

Top module: `uart_tx_fifo`

## Requirements
- R1: After reset `txd`=1, `hold_empty`=1, `shift_empty`=1, `irq`=0 and `overflow`=0. The line is high whenever `shift_empty` is 1.
- R2: With `fifo_en`=1, up to 64 bytes can wait behind the byte being sent. They are transmitted in write order.
- R3: With `fifo_en`=0, only one byte can wait behind the byte being sent.
- R4: A frame is one low start bit followed by the data bits, bit 0 first. The number of data bits is set by `data_len`: 00=5, 01=6, 10=7, 11=8.
- R5: When `parity_en`=1, one parity bit follows the data. `parity_sel` chooses it: 00 odd (data ones plus parity bit is odd), 01 even, 10 constant 1, 11 constant 0. Only the transmitted data bits are counted.
- R6: The frame ends with one high stop bit when `stop2`=0, or two when `stop2`=1.
- R7: A bit lasts 16 `tick` strobes, or 8 when `os8_mode`=1. The sequencer does not advance without a strobe.
- R8: `hold_empty` goes to 1 once the last waiting byte has moved into the sequencer. It is 0 while any byte waits.
- R9: `shift_empty` is 1 only when nothing waits and the last stop bit has fully ended. It is 0 during a stop bit.
- R10: A pending-interrupt bit is set when `hold_empty` changes from 0 to 1. `irq` equals pending AND `irq_en`.
- R11: The pending bit is cleared by a write, or by `irq_ack` while `hold_empty` is 1. The write, or the acknowledge, is accepted at a clock edge, and `irq` is 0 after that edge.
- R12: A write that finds the store full is dropped. It sets `overflow`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling strobe, one clock wide |
| os8_mode | input | 1 | 1: 8 strobes per bit, 0: 16 |
| fifo_en | input | 1 | 1: 64-byte queue, 0: single holding byte |
| data_len | input | 2 | Data bits per frame, minus 5 |
| parity_en | input | 1 | Insert a parity bit |
| parity_sel | input | 2 | Parity kind: odd, even, constant 1, constant 0 |
| stop2 | input | 1 | Two stop bits when 1 |
| irq_en | input | 1 | Transmit interrupt enable |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Byte to transmit |
| irq_ack | input | 1 | Interrupt status read |
| txd | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | No byte waiting |
| shift_empty | output | 1 | Nothing waiting and line idle |
| irq | output | 1 | Transmit interrupt |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
The hardest state to reach is a full store. Normally the sequencer drains a byte every frame, so the bench stops the strobe first. The first byte then sits in START while 64 more are queued, and the 66th write must be dropped. The strobe is then restarted, and all 65 frames are checked in order against the scoreboard. The same stalled-strobe trick is used for the single-byte mode. It is also used to show that a write clears the interrupt while `hold_empty` stays low.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP
    } tx_state_t;

    typedef enum logic [1:0] {
        PAR_ODD  = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ONE  = 2'b10,
        PAR_ZERO = 2'b11
    } par_kind_t;
endpackage

// File: rtl/uart_tx_buf.sv
module uart_tx_buf #(
    parameter int DEPTH = 64,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fifo_en,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic         drop
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] count;
    logic [CW-1:0] cap;
    logic          do_push, do_pop;

    always_comb begin
        cap     = fifo_en ? CW'(DEPTH) : CW'(1);
        empty   = (count == '0);
        full    = (count >= cap);
        do_pop  = pop && !empty;
        do_push = push && !full;
        drop    = push && full;
        head    = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r12_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> count == $past(count));
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_tx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int W   = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         os8,
    input  logic [1:0]   data_len,
    input  logic         par_en,
    input  logic [1:0]   par_sel,
    input  logic         stop2,
    input  logic         avail,
    input  logic [W-1:0] head,
    output logic         pop,
    output logic         txd,
    output logic         busy
);
    localparam int TW = $clog2(OVS);
    localparam int BW = $clog2(W);

    tx_state_t      state, nxt;
    logic [TW-1:0]  tcnt, tlast;
    logic [W-1:0]   sh;
    logic [BW-1:0]  bidx, blast;
    logic           sidx;
    logic           par_bit, par_calc;
    logic           bit_done;
    logic [W-1:0]   mask;

    always_comb begin
        tlast    = os8 ? TW'(OVS / 2 - 1) : TW'(OVS - 1);
        bit_done = tick && (tcnt == tlast);
        blast    = BW'(4) + BW'(data_len);
        mask     = {W{1'b1}} >> (2'd3 - data_len);
        unique case (par_kind_t'(par_sel))
            PAR_ODD:  par_calc = ~^(head & mask);
            PAR_EVEN: par_calc = ^(head & mask);
            PAR_ONE:  par_calc = 1'b1;
            PAR_ZERO: par_calc = 1'b0;
        endcase
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (avail) nxt = S_START;
            S_START:  if (bit_done) nxt = S_DATA;
            S_DATA:   if (bit_done && bidx == blast) nxt = par_en ? S_PARITY : S_STOP;
            S_PARITY: if (bit_done) nxt = S_STOP;
            S_STOP:   if (bit_done && (!stop2 || sidx)) nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            tcnt    <= '0;
            sh      <= '0;
            bidx    <= '0;
            sidx    <= 1'b0;
            par_bit <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_IDLE) tcnt <= '0;
            else if (tick)       tcnt <= bit_done ? '0 : tcnt + 1'b1;
            if (pop) begin
                sh      <= head;
                bidx    <= '0;
                sidx    <= 1'b0;
                par_bit <= par_calc;
            end else if (bit_done && state == S_DATA) begin
                sh   <= sh >> 1;
                bidx <= bidx + 1'b1;
            end
            if (bit_done && state == S_STOP) sidx <= 1'b1;
        end
    end

    always_comb begin
        pop  = 1'b0;
        txd  = 1'b1;
        busy = 1'b1;
        unique case (state)
            S_IDLE:   begin pop = avail; busy = 1'b0; end
            S_START:  txd = 1'b0;
            S_DATA:   txd = sh[0];
            S_PARITY: txd = par_bit;
            S_STOP:   txd = 1'b1;
        endcase
    end

    a_r4_pop_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (state == S_START) && !txd);
    a_r7_no_strobe_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && state != S_IDLE) |=> state == $past(state));
endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int DEPTH = 64,
    parameter int OVS   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       os8_mode,
    input  logic       fifo_en,
    input  logic [1:0] data_len,
    input  logic       parity_en,
    input  logic [1:0] parity_sel,
    input  logic       stop2,
    input  logic       irq_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       irq_ack,
    output logic       txd,
    output logic       hold_empty,
    output logic       shift_empty,
    output logic       irq,
    output logic       overflow
);
    localparam int W = 8;

    logic [W-1:0] head;
    logic         empty, full, drop, pop, busy;
    logic         he_q, pend;

    uart_tx_buf #(.DEPTH(DEPTH), .W(W)) u_buf (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .push(wr_en), .push_data(wr_data), .pop(pop),
        .head(head), .empty(empty), .full(full), .drop(drop)
    );

    uart_tx_shift #(.OVS(OVS), .W(W)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick(tick), .os8(os8_mode),
        .data_len(data_len), .par_en(parity_en), .par_sel(parity_sel),
        .stop2(stop2), .avail(!empty), .head(head),
        .pop(pop), .txd(txd), .busy(busy)
    );

    always_comb begin
        hold_empty  = empty;
        shift_empty = empty && !busy;
        irq         = pend && irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            he_q     <= 1'b1;
            pend     <= 1'b0;
            overflow <= 1'b0;
        end else begin
            he_q <= hold_empty;
            if (wr_en || (irq_ack && hold_empty)) pend <= 1'b0;
            else if (hold_empty && !he_q)         pend <= 1'b1;
            if (drop) overflow <= 1'b1;
        end
    end

    a_r1_line_high_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> txd);
    a_r9_shift_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> hold_empty);
    a_r11_write_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !irq);
    a_r12_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

// File: tb/uart_tx_fifo_test.sv
module uart_tx_fifo_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       ph = 1'b0;
    logic       tick_on = 1'b1;
    logic       os8_mode = 1'b0, fifo_en = 1'b1, parity_en = 1'b0, stop2 = 1'b0;
    logic       irq_en = 1'b0, wr_en = 1'b0, irq_ack = 1'b0;
    logic [1:0] data_len = 2'b11, parity_sel = 2'b00;
    logic [7:0] wr_data = 8'h00;
    logic       txd, hold_empty, shift_empty, irq, overflow;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];

    uart_tx_fifo uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .os8_mode(os8_mode),
        .fifo_en(fifo_en), .data_len(data_len), .parity_en(parity_en),
        .parity_sel(parity_sel), .stop2(stop2), .irq_en(irq_en),
        .wr_en(wr_en), .wr_data(wr_data), .irq_ack(irq_ack),
        .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty),
        .irq(irq), .overflow(overflow)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        ph   <= ~ph;
        tick <= tick_on & ph;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic exp_par(input logic [7:0] d);
        logic [7:0] m;
        m = d & (8'hFF >> (2'd3 - data_len));
        case (parity_sel)
            2'b00:   return ~^m;
            2'b01:   return ^m;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic wr(input logic [7:0] d, input bit accept);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        if (accept) exp_q.push_back(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!shift_empty) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic start_bit_len(input int lo, input int hi, input string req);
        int n;
        n = 0;
        @(negedge clk);
        while (txd) @(negedge clk);
        while (!txd) begin
            n++;
            @(negedge clk);
        end
        chk(n >= lo && n <= hi, req, "start bit clocks", n, hi);
    endtask

    // Scoreboard monitor: decodes each frame and compares with the queue
    initial begin
        int bp, nb, ns;
        logic [7:0] got, expd;
        forever begin
            @(negedge clk);
            if (rst_n && tick_on && !txd) begin
                bp  = (os8_mode ? 8 : 16) * 2;
                nb  = int'(data_len) + 5;
                ns  = stop2 ? 2 : 1;
                got = 8'h00;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected frame", 1, 0);
                    expd = 8'h00;
                end else begin
                    expd = exp_q.pop_front();
                end
                repeat (bp / 2) @(negedge clk);
                chk(txd == 1'b0, "R4", "start bit level", int'(txd), 0);
                for (int i = 0; i < nb; i++) begin
                    repeat (bp) @(negedge clk);
                    got[i] = txd;
                end
                chk(got == (expd & (8'hFF >> (2'd3 - data_len))), "R4", "data bits",
                    int'(got), int'(expd & (8'hFF >> (2'd3 - data_len))));
                if (parity_en) begin
                    repeat (bp) @(negedge clk);
                    chk(txd == exp_par(expd), "R5", "parity bit", int'(txd), int'(exp_par(expd)));
                end
                for (int s = 0; s < ns; s++) begin
                    repeat (bp) @(negedge clk);
                    chk(txd == 1'b1, "R6", "stop bit level", int'(txd), 1);
                end
                chk(shift_empty == 1'b0, "R9", "shift_empty during stop", int'(shift_empty), 0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
        chk(hold_empty == 1'b1, "R1", "hold_empty after reset", int'(hold_empty), 1);
        chk(shift_empty == 1'b1, "R1", "shift_empty after reset", int'(shift_empty), 1);
        chk(irq == 1'b0, "R1", "irq after reset", int'(irq), 0);
        chk(overflow == 1'b0, "R1", "overflow after reset", int'(overflow), 0);

        // R4 R6: 8 data bits, no parity, one stop bit, several bytes
        wr(8'h01, 1);
        start_bit_len(31, 33, "R7");
        wr(8'hA5, 1);
        wr(8'h3C, 1);
        wr(8'hFF, 1);
        wait_idle();
        chk(shift_empty == 1'b1, "R9", "shift_empty after frames", int'(shift_empty), 1);
        chk(hold_empty == 1'b1, "R8", "hold_empty after frames", int'(hold_empty), 1);

        // R5 R6: 7 bits, even parity, two stop bits
        data_len = 2'b10; parity_en = 1'b1; parity_sel = 2'b01; stop2 = 1'b1;
        wr(8'h55, 1); wr(8'hF3, 1); wr(8'h80, 1);
        wait_idle();
        // R5: 5 bits odd parity
        data_len = 2'b00; parity_sel = 2'b00; stop2 = 1'b0;
        wr(8'h1B, 1); wr(8'hE0, 1);
        wait_idle();
        // R5: 6 bits constant 1, then constant 0
        data_len = 2'b01; parity_sel = 2'b10;
        wr(8'h2A, 1);
        wait_idle();
        parity_sel = 2'b11;
        wr(8'h3F, 1);
        wait_idle();

        // R7: half-rate bit timing
        os8_mode = 1'b1; data_len = 2'b11; parity_en = 1'b0;
        wr(8'hC3, 1);
        start_bit_len(15, 17, "R7");
        wr(8'h5A, 1);
        wait_idle();
        os8_mode = 1'b0;

        // R10 R11: interrupt set, masked, acknowledged, cleared by write
        irq_en = 1'b1;
        wr(8'h96, 1);
        repeat (4) @(negedge clk);
        chk(irq == 1'b1, "R10", "irq after hold_empty rise", int'(irq), 1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk(irq == 1'b0, "R11", "irq after ack", int'(irq), 0);
        wait_idle();
        chk(irq == 1'b0, "R11", "irq stays clear", int'(irq), 0);
        irq_en = 1'b0;
        wr(8'h69, 1);
        repeat (4) @(negedge clk);
        chk(irq == 1'b0, "R10", "irq masked", int'(irq), 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R10", "irq after enable", int'(irq), 1);
        wait_idle();
        @(posedge clk) tick_on = 1'b0;
        wr(8'h11, 1);
        repeat (4) @(negedge clk);
        chk(irq == 1'b1, "R10", "irq with stalled strobe", int'(irq), 1);
        wr(8'h22, 1);
        @(negedge clk);
        chk(irq == 1'b0, "R11", "irq after write", int'(irq), 0);
        chk(hold_empty == 1'b0, "R8", "hold_empty with waiting byte", int'(hold_empty), 0);
        @(posedge clk) tick_on = 1'b1;
        wait_idle();
        irq_en = 1'b0;

        // R2 R12: fill the queue with the strobe stopped
        do_reset();
        @(posedge clk) tick_on = 1'b0;
        for (int i = 0; i < 65; i++) wr(8'(i * 7 + 3), 1);
        @(negedge clk);
        chk(overflow == 1'b0, "R12", "overflow before full write", int'(overflow), 0);
        chk(hold_empty == 1'b0, "R8", "hold_empty when full", int'(hold_empty), 0);
        wr(8'hEE, 0);
        @(negedge clk);
        chk(overflow == 1'b1, "R12", "overflow after dropped write", int'(overflow), 1);
        @(posedge clk) tick_on = 1'b1;
        wait_idle();
        chk(exp_q.size() == 0, "R2", "frames left unsent", exp_q.size(), 0);
        chk(overflow == 1'b1, "R12", "overflow sticky", int'(overflow), 1);

        // R3: single holding byte
        do_reset();
        fifo_en = 1'b0;
        @(posedge clk) tick_on = 1'b0;
        wr(8'h4D, 1);
        wr(8'hB2, 1);
        @(negedge clk);
        chk(overflow == 1'b0, "R3", "second byte accepted", int'(overflow), 0);
        wr(8'h77, 0);
        @(negedge clk);
        chk(overflow == 1'b1, "R3", "third byte dropped", int'(overflow), 1);
        @(posedge clk) tick_on = 1'b1;
        wait_idle();
        chk(exp_q.size() == 0, "R3", "frames left unsent", exp_q.size(), 0);
        chk(txd == 1'b1, "R1", "line idle high", int'(txd), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule